// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a scratchpad of 32-bit words split into 16 single-ported banks. It serves 16 lanes per request. Each lane carries an active flag, a word address, a write enable and write data. The bank that holds a word is given by the low four bits of its word address. The row inside that bank is given by the remaining high bits.

A request is accepted through a valid/ready handshake. The block then issues one or more memory rounds. In each round every bank performs at most one access. Lanes whose banks differ proceed together. Lanes that read the same word in the same bank are merged into one broadcast access. Any other lanes that share a bank are spread across later rounds, in ascending lane order.

Each round returns a mask of the lanes it finished, with their read data valid in the same cycle. When the last round is done, a completion strobe reports how many rounds the request used. That count equals the load on the busiest bank.

Top module: `bank_serializer`

## Requirements
- R1: A word address of 8 bits selects its bank by bits [3:0] and its row by bits [7:4]. Two active lanes with addresses 5 and 21 share bank 5 and need 2 rounds. Addresses 5 and 6 need 1 round.
- R2: A request whose active lanes all fall in different banks finishes in one round. The round's `laneDone` and `reqDone` are seen in the second cycle after the accepting edge. In general, `reqDone` comes exactly k cycles after acceptance for k rounds.
- R3: Active read lanes that address the same word are served in one round, and every one of them receives that word. All 16 lanes reading one address take 1 round.
- R4: `roundCount` equals the largest per-bank load. A bank's load is its number of write lanes plus its number of distinct read addresses. A stride of 2 across 16 lanes gives 2 rounds, a stride of 8 gives 8, and a stride of 16 gives 16.
- R5: Within a bank, pending lanes are granted in ascending lane order. A lane's `rdData` slice is valid in the cycle in which its `laneDone` bit is 1, and each active lane's bit is 1 exactly once per request.
- R6: When several active lanes write the same word in one request, the word afterwards holds the data of the highest-numbered of those lanes.
- R7: `reqReady` is 0 from the cycle after acceptance until the cycle in which `reqDone` is 1. Requests presented meanwhile are ignored and write nothing.
- R8: `reqDone` is a one-cycle pulse. A request with no active lane completes after one cycle with `roundCount` equal to 0.
- R9: Inactive lanes are never marked done and never write memory. The union of `laneDone` over a request equals its `laneActive` mask.
- R10: After reset, `reqReady` is 1 and `reqDone` and `laneDone` are 0.
- R11: A read granted in a later round of a request returns data written by a lower lane of the same request in an earlier round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| laneActive | input | 16 | Per-lane participation flag |
| laneAddr | input | 128 | Per-lane word address, lane n at bits [8n+7:8n] |
| laneWrite | input | 16 | Per-lane write enable |
| laneWdata | input | 512 | Per-lane write data, lane n at bits [32n+31:32n] |
| rdData | output | 512 | Per-lane read data, lane n at bits [32n+31:32n] |
| laneDone | output | 16 | Lanes finished in the round just completed |
| reqDone | output | 1 | Completion pulse for the request |
| roundCount | output | 5 | Rounds used by the completed request |

## Verification
The checker assumes that `laneActive` stays stable from the accepting edge onward while its own copy is in use. It also assumes that nothing outside the handshake clears a request in flight. Under those assumptions it checks that the done lanes of each request are a subset of the active mask with no lane repeated, that together they cover the whole mask at completion, and that the reported round count matches the rounds with a non-empty done mask. The bench changes inputs only on falling edges and holds the request fields until the accepting edge. During busy periods it presents only deliberately ignored requests. It never mixes a read and a write of one word in a request, except in the directed case where the expected ordering is stated.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
  typedef struct packed {
    logic capture;  // latch a new request
    logic access;   // perform one memory round
  } ctrlStrobe_t;
endpackage

// File: rtl/bank_grant.sv
`timescale 1ns/1ps
// Picks the lanes served in the current round: the lowest pending lane of
// each bank, plus pending readers of the same word when that lane reads.
module bank_grant #(
  parameter int LANES  = 16,
  parameter int BANK_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addrQ,
  input  logic [LANES-1:0]        writeQ,
  output logic [LANES-1:0]        grant
);
  logic [LANES-1:0] lead;

  always_comb begin
    lead  = '0;
    grant = '0;
    for (int i = 0; i < LANES; i++) begin
      lead[i] = pending[i];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && pending[j] &&
            addrQ[j*ADDR_W +: BANK_W] == addrQ[i*ADDR_W +: BANK_W])
          lead[i] = 1'b0;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      grant[i] = lead[i];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && lead[j] && !writeQ[j] && pending[i] && !writeQ[i] &&
            addrQ[j*ADDR_W +: ADDR_W] == addrQ[i*ADDR_W +: ADDR_W])
          grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_ctrl.sv
`timescale 1ns/1ps
module bank_ctrl import bank_pkg::*; #(
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LANES-1:0] laneActive,
  input  logic [LANES-1:0] grant,
  output logic             reqReady,
  output logic [LANES-1:0] pending,
  output ctrlStrobe_t      strobe,
  output logic             reqDone,
  output logic [CNT_W-1:0] roundCount
);
  logic             busy;
  logic [CNT_W-1:0] rounds;
  logic             accept;
  logic [LANES-1:0] remain;
  logic [CNT_W-1:0] roundStep;

  assign accept         = reqValid && !busy;
  assign reqReady       = !busy;
  assign strobe.capture = accept;
  assign strobe.access  = busy;
  assign remain         = pending & ~grant;
  assign roundStep      = {{(CNT_W-1){1'b0}}, |grant};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      pending    <= '0;
      rounds     <= '0;
      reqDone    <= 1'b0;
      roundCount <= '0;
    end else begin
      reqDone <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        pending <= laneActive;
        rounds  <= '0;
      end else if (busy) begin
        pending <= remain;
        rounds  <= rounds + roundStep;
        if (remain == '0) begin
          busy       <= 1'b0;
          reqDone    <= 1'b1;
          roundCount <= rounds + roundStep;
        end
      end
    end
  end
endmodule

// File: rtl/bank_datapath.sv
`timescale 1ns/1ps
module bank_datapath import bank_pkg::*; #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(DEPTH),
  localparam int ADDR_W = BANK_W + ROW_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES-1:0]        laneWrite,
  input  logic [LANES*DATA_W-1:0] laneWdata,
  input  logic [LANES-1:0]        grant,
  output logic [LANES*ADDR_W-1:0] addrQ,
  output logic [LANES-1:0]        writeQ,
  output logic [LANES*DATA_W-1:0] rdData,
  output logic [LANES-1:0]        laneDone
);
  logic [DATA_W-1:0] wdataQ [LANES];
  logic [DATA_W-1:0] mem [BANKS][DEPTH];
  logic [BANKS-1:0]  bankWe;
  logic [ROW_W-1:0]  bankRow [BANKS];
  logic [DATA_W-1:0] bankWd [BANKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= '0;
      for (int l = 0; l < LANES; l++) wdataQ[l] <= '0;
    end else if (strobe.capture) begin
      addrQ  <= laneAddr;
      writeQ <= laneWrite;
      for (int l = 0; l < LANES; l++) wdataQ[l] <= laneWdata[l*DATA_W +: DATA_W];
    end
  end

  // At most one writer per bank is granted in a round.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankWe[b]  = 1'b0;
      bankRow[b] = '0;
      bankWd[b]  = '0;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l] && writeQ[l] && addrQ[l*ADDR_W +: BANK_W] == BANK_W'(b)) begin
          bankWe[b]  = 1'b1;
          bankRow[b] = addrQ[l*ADDR_W+BANK_W +: ROW_W];
          bankWd[b]  = wdataQ[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.access) begin
      for (int b = 0; b < BANKS; b++)
        if (bankWe[b]) mem[b][bankRow[b]] <= bankWd[b];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BANK_W-1:0] bankSel;
    logic [ROW_W-1:0]  rowSel;
    logic [DATA_W-1:0] readQ;
    assign bankSel = addrQ[l*ADDR_W +: BANK_W];
    assign rowSel  = addrQ[l*ADDR_W+BANK_W +: ROW_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) readQ <= '0;
      else if (strobe.access && grant[l]) readQ <= mem[bankSel][rowSel];
    end
    assign rdData[l*DATA_W +: DATA_W] = readQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) laneDone <= '0;
    else       laneDone <= strobe.access ? grant : '0;
  end
endmodule

// File: rtl/bank_serializer.sv
`timescale 1ns/1ps
module bank_serializer import bank_pkg::*; #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = BANK_W + $clog2(DEPTH),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES-1:0]        laneActive,
  input  logic [LANES*ADDR_W-1:0] laneAddr,
  input  logic [LANES-1:0]        laneWrite,
  input  logic [LANES*DATA_W-1:0] laneWdata,
  output logic [LANES*DATA_W-1:0] rdData,
  output logic [LANES-1:0]        laneDone,
  output logic                    reqDone,
  output logic [CNT_W-1:0]        roundCount
);
  ctrlStrobe_t             strobe;
  logic [LANES-1:0]        pending;
  logic [LANES-1:0]        grant;
  logic [LANES*ADDR_W-1:0] addrQ;
  logic [LANES-1:0]        writeQ;

  bank_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .laneActive(laneActive),
    .grant(grant), .reqReady(reqReady), .pending(pending), .strobe(strobe),
    .reqDone(reqDone), .roundCount(roundCount)
  );

  bank_grant #(.LANES(LANES), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_grant (
    .pending(pending), .addrQ(addrQ), .writeQ(writeQ), .grant(grant)
  );

  bank_datapath #(.LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneAddr(laneAddr),
    .laneWrite(laneWrite), .laneWdata(laneWdata), .grant(grant),
    .addrQ(addrQ), .writeQ(writeQ), .rdData(rdData), .laneDone(laneDone)
  );
endmodule

// File: rtl/bank_serializer_chk.sv
`timescale 1ns/1ps
module bank_serializer_chk #(
  parameter int LANES = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LANES-1:0] laneActive,
  input logic [LANES-1:0] laneDone,
  input logic             reqDone,
  input logic [CNT_W-1:0] roundCount
);
  logic             inFlight;
  logic [LANES-1:0] maskQ;
  logic [LANES-1:0] doneAcc;
  logic [CNT_W-1:0] roundsSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight   <= 1'b0;
      maskQ      <= '0;
      doneAcc    <= '0;
      roundsSeen <= '0;
    end else if (reqValid && reqReady) begin
      inFlight   <= 1'b1;
      maskQ      <= laneActive;
      doneAcc    <= '0;
      roundsSeen <= '0;
    end else if (inFlight) begin
      doneAcc    <= doneAcc | laneDone;
      roundsSeen <= roundsSeen + {{(CNT_W-1){1'b0}}, |laneDone};
      if (reqDone) inFlight <= 1'b0;
    end
  end

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  p_ready_at_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> reqReady);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inFlight |-> (laneDone == '0));
  p_done_in_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> ((laneDone & ~maskQ) == '0));
  p_no_repeat_r5: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> ((laneDone & doneAcc) == '0));
  p_all_served_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && reqDone) |-> ((doneAcc | laneDone) == maskQ));
  p_round_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && reqDone) |-> (roundCount == roundsSeen + {{(CNT_W-1){1'b0}}, |laneDone}));
endmodule

bind bank_serializer bank_serializer_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .laneActive(laneActive), .laneDone(laneDone), .reqDone(reqDone),
  .roundCount(roundCount)
);

// File: tb/bank_serializer_test.sv
`timescale 1ns/1ps
module bank_serializer_test;
  localparam int LANES = 16;
  localparam int DW    = 32;
  localparam int AW    = 8;
  localparam int CW    = 5;
  localparam int NV    = 13;

  // Vector table: base address, stride, active mask, write mask, expected rounds.
  localparam logic [7:0]  V_BASE   [NV] = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd37, 8'd3, 8'd5,
                                            8'd0, 8'd0, 8'd9, 8'd100, 8'd100, 8'd40};
  localparam logic [7:0]  V_STRIDE [NV] = '{8'd1, 8'd1, 8'd2, 8'd8, 8'd0, 8'd16, 8'd3,
                                            8'd2, 8'd4, 8'd0, 8'd2, 8'd2, 8'd0};
  localparam logic [15:0] V_ACT    [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF,
                                            16'hFFFF, 16'hFFFF, 16'h00FF, 16'h5555, 16'h0000,
                                            16'hFFFF, 16'hFFFF, 16'hAAAA};
  localparam logic [15:0] V_WR     [NV] = '{16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                            16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                            16'hFFFF, 16'h0000, 16'h0000};
  localparam int          V_EXP    [NV] = '{1, 1, 2, 8, 1, 16, 1, 1, 4, 0, 2, 2, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [LANES-1:0] laneActive = '0;
  logic [LANES*AW-1:0] laneAddr = '0;
  logic [LANES-1:0] laneWrite = '0;
  logic [LANES*DW-1:0] laneWdata = '0;
  logic [LANES*DW-1:0] rdData;
  logic [LANES-1:0] laneDone;
  logic reqDone;
  logic [CW-1:0] roundCount;

  always #2.5 clk = ~clk;

  bank_serializer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .laneActive(laneActive), .laneAddr(laneAddr), .laneWrite(laneWrite),
    .laneWdata(laneWdata), .rdData(rdData), .laneDone(laneDone),
    .reqDone(reqDone), .roundCount(roundCount)
  );

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0]  tbAddr [LANES];
  logic [31:0] tbWd [LANES];
  logic [31:0] model [256];
  int          gotRounds;
  int          gotCycles;
  logic [15:0] gotMask;
  logic [31:0] gotData [LANES];
  int          gotRound [LANES];
  bit          readyBad;
  bit          hung;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wval(input int tag, input int lane, input int addr);
    return {8'(tag), 8'h3C, 8'(addr), 8'(lane)};
  endfunction

  task automatic setPattern(input int base, input int stride, input int tag);
    for (int l = 0; l < LANES; l++) begin
      tbAddr[l] = 8'(base + l * stride);
      tbWd[l]   = wval(tag, l, int'(tbAddr[l]));
    end
  endtask

  task automatic applyModel(input logic [15:0] act, input logic [15:0] wr);
    for (int l = 0; l < LANES; l++)
      if (act[l] && wr[l]) model[tbAddr[l]] = tbWd[l];
  endtask

  // Issues one request and samples every round on falling edges.
  task automatic doReq(input logic [15:0] act, input logic [15:0] wr, input bit junk);
    @(negedge clk);
    laneActive = act;
    laneWrite  = wr;
    for (int l = 0; l < LANES; l++) begin
      laneAddr[l*AW +: AW]  = tbAddr[l];
      laneWdata[l*DW +: DW] = tbWd[l];
      gotRound[l] = 0;
      gotData[l]  = '0;
    end
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      laneActive = '1;
      laneWrite  = '1;
      for (int l = 0; l < LANES; l++) begin
        laneAddr[l*AW +: AW]  = 8'd200;
        laneWdata[l*DW +: DW] = 32'hDEAD0000 + l;
      end
    end else begin
      reqValid = 1'b0;
    end
    gotCycles = 0;
    gotMask   = '0;
    gotRounds = -1;
    readyBad  = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      gotCycles++;
      for (int l = 0; l < LANES; l++)
        if (laneDone[l]) begin
          gotData[l]  = rdData[l*DW +: DW];
          gotRound[l] = gotCycles;
        end
      gotMask = gotMask | laneDone;
      if (reqDone) begin
        gotRounds = int'(roundCount);
        break;
      end
      if (reqReady) readyBad = 1'b1;
    end
    reqValid = 1'b0;
    chk(gotRounds >= 0, "R8 completion pulse seen", 32'(gotRounds), 32'd1);
  endtask

  initial begin
    hung = 1'b0;
    repeat (100000) @(posedge clk);
    hung = 1'b1;
    nChecks++;
    nErrors++;
    $display("FAIL R7 watchdog actual=hung expected=complete");
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(reqReady == 1'b1, "R10 reqReady", 32'(reqReady), 32'd1);
    chk(reqDone == 1'b0, "R10 reqDone", 32'(reqDone), 32'd0);
    chk(laneDone == '0, "R10 laneDone", 32'(laneDone), 32'd0);

    // Preload every word, 16 distinct banks per request (R2).
    for (int k = 0; k < 16; k++) begin
      setPattern(16 * k, 1, k + 1);
      doReq(16'hFFFF, 16'hFFFF, 1'b0);
      chk(gotRounds == 1, "R2 preload rounds", 32'(gotRounds), 32'd1);
      applyModel(16'hFFFF, 16'hFFFF);
    end

    // Table walk (R2, R3, R4, R9).
    for (int v = 0; v < NV; v++) begin
      setPattern(int'(V_BASE[v]), int'(V_STRIDE[v]), 50 + v);
      doReq(V_ACT[v], V_WR[v], 1'b0);
      chk(gotRounds == V_EXP[v], "R4 round count", 32'(gotRounds), 32'(V_EXP[v]));
      chk(gotMask == V_ACT[v], "R9 done mask", 32'(gotMask), 32'(V_ACT[v]));
      chk(gotCycles == ((V_EXP[v] == 0) ? 1 : V_EXP[v]), "R2 latency",
          32'(gotCycles), 32'((V_EXP[v] == 0) ? 1 : V_EXP[v]));
      for (int l = 0; l < LANES; l++)
        if (V_ACT[v][l] && !V_WR[v][l])
          chk(gotData[l] == model[tbAddr[l]], "R3 read data", gotData[l], model[tbAddr[l]]);
      applyModel(V_ACT[v], V_WR[v]);
    end

    // R1: bank from low four address bits.
    tbAddr[0] = 8'd5; tbAddr[1] = 8'd21;
    doReq(16'h0003, 16'h0000, 1'b0);
    chk(gotRounds == 2, "R1 same bank rounds", 32'(gotRounds), 32'd2);
    chk(gotData[1] == model[21], "R1 row data", gotData[1], model[21]);
    tbAddr[1] = 8'd6;
    doReq(16'h0003, 16'h0000, 1'b0);
    chk(gotRounds == 1, "R1 neighbour bank rounds", 32'(gotRounds), 32'd1);

    // R5: ascending lane order inside one bank.
    setPattern(3, 16, 90);
    doReq(16'hFFFF, 16'h0000, 1'b0);
    for (int l = 0; l < LANES; l++)
      chk(gotRound[l] == l + 1, "R5 grant order", 32'(gotRound[l]), 32'(l + 1));

    // R6: same-word writes, highest lane wins.
    for (int l = 0; l < LANES; l++) begin
      tbAddr[l] = 8'd50;
      tbWd[l]   = wval(91, l, 50);
    end
    doReq(16'hFFFF, 16'hFFFF, 1'b0);
    chk(gotRounds == 16, "R6 write rounds", 32'(gotRounds), 32'd16);
    applyModel(16'hFFFF, 16'hFFFF);
    doReq(16'h0001, 16'h0000, 1'b0);
    chk(gotData[0] == wval(91, 15, 50), "R6 final word", gotData[0], wval(91, 15, 50));

    // R11: read after earlier-round write of the same request.
    tbAddr[0] = 8'd7; tbWd[0] = wval(92, 0, 7);
    tbAddr[1] = 8'd7; tbWd[1] = 32'h0;
    doReq(16'h0003, 16'h0001, 1'b0);
    chk(gotRounds == 2, "R11 rounds", 32'(gotRounds), 32'd2);
    chk(gotData[1] == wval(92, 0, 7), "R11 forwarded data", gotData[1], wval(92, 0, 7));
    applyModel(16'h0003, 16'h0001);

    // R7: busy requests ignored, ready low while busy.
    setPattern(60, 16, 93);
    doReq(16'h000F, 16'h000F, 1'b1);
    chk(gotRounds == 4, "R7 busy request rounds", 32'(gotRounds), 32'd4);
    chk(readyBad == 1'b0, "R7 ready low while busy", 32'(readyBad), 32'd0);
    applyModel(16'h000F, 16'h000F);
    tbAddr[0] = 8'd200;
    doReq(16'h0001, 16'h0000, 1'b0);
    chk(gotData[0] == model[200], "R7 ignored write", gotData[0], model[200]);

    // R8: empty request and one-cycle pulse.
    doReq(16'h0000, 16'h0000, 1'b0);
    chk(gotRounds == 0, "R8 empty count", 32'(gotRounds), 32'd0);
    chk(gotCycles == 1, "R8 empty latency", 32'(gotCycles), 32'd1);
    @(negedge clk);
    chk(reqDone == 1'b0, "R8 pulse width", 32'(reqDone), 32'd0);

    // R9: inactive lanes write nothing.
    setPattern(120, 1, 94);
    doReq(16'h00FF, 16'hFFFF, 1'b0);
    applyModel(16'h00FF, 16'hFFFF);
    setPattern(120, 1, 95);
    doReq(16'hFFFF, 16'h0000, 1'b0);
    for (int l = 0; l < LANES; l++)
      chk(gotData[l] == model[tbAddr[l]], "R9 untouched word", gotData[l], model[tbAddr[l]]);

    if (!hung) begin
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule